// File: doc/BRIEF.md
# Feature Header Chain Walker

This block walks a linked chain of 64-bit feature descriptors kept in a memory-mapped region. A start pulse loads a base byte address. The walker then fetches each descriptor word through a single-outstanding read port and decodes the fields. For every descriptor it emits one record, then moves on by the relative byte offset the descriptor holds. The walk ends at the descriptor whose last-entry flag is set, or at the first fault.

Descriptors come in two layouts, chosen by the version field. The older layout has a 128-bit unique identifier only for two designated kinds. The newer layout always has the identifier, and adds a word that locates the feature's registers and a word that gives their size and grouping. It can also chain a sub-list of parameter headers, and the walker reports the ID and version of each one. A done pulse closes each walk. It comes with an error flag and a count of the records reported, and both hold until the next accepted start.

Top module: `hdr_walker`

## Requirements
- R1: After reset the block is idle: `rd_req_o`, `feat_valid_o`, `param_valid_o`, `done_o` and `err_o` are 0, and `count_o` is 0.
- R2: The first word of a descriptor is decoded as follows: kind in bits 63:60, version in 59:52, last-entry flag in bit 40, next offset in 39:16, revision in 15:12, ID in 11:0. Bits 51:41 are ignored. The record reports these fields and the byte address of the descriptor.
- R3: When the last-entry flag is 0, the next descriptor is read at the current descriptor address plus the next field, taken in bytes. When the flag is 1, the walk ends after that record with `done_o`, `err_o`=0 and `count_o` equal to the number of records.
- R4: The low 64 bits of the identifier come from offset +8 and the high 64 bits from +16. Version 1 always has the identifier. Any other version has it only for kinds `GUID_KIND_A` (default 1) and `GUID_KIND_B` (default 4). When it is absent, the words are not read and the identifier is reported as 0.
- R5: Version 1 reads a location word at +24. Bits 63:1 with bit 0 cleared form an address. If bit 0 is 1, that address is absolute and `feat_regabs_o` is 1. Otherwise the descriptor address is added to it. In other versions the location is the descriptor address and `feat_regabs_o` is 0.
- R6: Version 1 reads a size word at +32: register size in bits 63:32, a parameters-present flag in bit 31, group in bits 30:16 and instance in bits 15:0. Other versions report size, group and instance as 0.
- R7: When the parameters-present flag is set, parameter headers are read starting at descriptor+40. Each header holds ID in bits 15:0, version in 31:16, end flag in bit 32, and in bits 63:35 a next offset counted in 8-byte words from that header. One `param_valid_o` pulse is given per header, after the descriptor's own record. After the header whose end flag is set, the walk goes on to the next descriptor.
- R8: A non-final descriptor whose next offset is 0 or not a multiple of 8 ends the walk with `err_o`=1 after its record. A base address that is not 8-byte aligned ends the walk with `err_o`=1 and no read.
- R9: If MAX_FEAT records have been reported and the last one is not final, the walk ends with `err_o`=1 and `count_o`=MAX_FEAT.
- R10: A parameter header with end flag 0 and next offset 0 ends the walk with `err_o`=1 after its pulse. So does the MAX_PARAM-th parameter header of one descriptor when its end flag is 0.
- R11: Each read is a one-cycle `rd_req_o` pulse with an 8-byte-aligned address. No new request is issued before `rd_valid_i` answers the previous one.
- R12: `start_i` is ignored while a walk is in progress.
- R13: `done_o` is a one-cycle pulse. `err_o` and `count_o` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (accepted only when idle) |
| base_i | input | AW | Byte address of the first descriptor |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | AW | Read byte address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Read response data |
| feat_valid_o | output | 1 | Descriptor record valid |
| feat_type_o | output | 4 | Descriptor kind |
| feat_ver_o | output | 8 | Descriptor layout version |
| feat_id_o | output | 12 | Feature ID |
| feat_rev_o | output | 4 | Feature revision |
| feat_addr_o | output | AW | Byte address of the descriptor |
| feat_guid_o | output | 128 | Unique identifier, or 0 |
| feat_regaddr_o | output | AW | Resolved register address |
| feat_regabs_o | output | 1 | Location was absolute |
| feat_regsize_o | output | 32 | Register space size in bytes |
| feat_group_o | output | 15 | Group ID |
| feat_inst_o | output | 16 | Instance ID |
| param_valid_o | output | 1 | Parameter record valid |
| param_id_o | output | 16 | Parameter ID |
| param_ver_o | output | 16 | Parameter version |
| done_o | output | 1 | Walk finished pulse |
| err_o | output | 1 | Walk ended on a fault |
| count_o | output | FCW | Number of descriptor records reported |

## Verification
A request appears on `rd_req_o` one cycle after the walker decides to fetch. A descriptor record appears the cycle after the response to its last word. A parameter record appears the cycle after its header's response. `done_o` follows two cycles after the final descriptor record, or one cycle after a failing parameter record. Because the memory model answers with a varying latency, the bench does not count cycles. It queues the expected records in walk order, and a monitor compares each valid pulse at the falling edge against the head of the matching queue. This keeps every comparison tied to the cycle in which the block marks its output valid.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [2:0] {
    K_H0, K_GL, K_GH, K_LOC, K_SZ, K_PRM
  } fetch_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_EMITF, S_EMITP, S_ADV, S_DONE
  } state_e;

  typedef struct packed {
    logic [3:0]  kind;
    logic [7:0]  ver;
    logic        last;
    logic [23:0] nxt;
    logic [3:0]  rev;
    logic [11:0] id;
  } hdr_t;

  typedef struct packed {
    logic [31:0] rsize;
    logic        pflag;
    logic [14:0] grp;
    logic [15:0] inst;
  } size_t;

  typedef struct packed {
    logic [28:0] nxt;
    logic        pend;
    logic [15:0] ver;
    logic [15:0] id;
  } prm_t;

  function automatic hdr_t unpack_hdr(input logic [63:0] w);
    return hdr_t'({w[63:52], w[40:0]});
  endfunction

  function automatic prm_t unpack_prm(input logic [63:0] w);
    return prm_t'({w[63:35], w[32:0]});
  endfunction

endpackage

// File: rtl/walk_rst_sync.sv
module walk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/walk_rd_port.sv
module walk_rd_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_valid_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          resp_ok_o
);
  logic          req_q, req_d, pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    req_d  = issue_i;
    addr_d = issue_i ? addr_i : addr_q;
    pend_d = pend_q;
    if (issue_i)         pend_d = 1'b1;
    else if (rd_valid_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
      addr_q <= addr_d;
    end
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
  assign resp_ok_o = rd_valid_i & pend_q;
endmodule

// File: rtl/walk_limit.sv
module walk_limit #(
  parameter int MAX = 16,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                          cnt_d = '0;
    else if (inc_i && cnt_q != CW'(MAX)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hdr_walker.sv
module hdr_walker
  import walker_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          MAX_FEAT    = 16,
  parameter int          MAX_PARAM   = 4,
  parameter logic [3:0]  GUID_KIND_A = 4'd1,
  parameter logic [3:0]  GUID_KIND_B = 4'd4,
  localparam int         FCW         = $clog2(MAX_FEAT + 1),
  localparam int         PCW         = $clog2(MAX_PARAM + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  base_i,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  input  logic           rd_valid_i,
  input  logic [63:0]    rd_data_i,
  output logic           feat_valid_o,
  output logic [3:0]     feat_type_o,
  output logic [7:0]     feat_ver_o,
  output logic [11:0]    feat_id_o,
  output logic [3:0]     feat_rev_o,
  output logic [AW-1:0]  feat_addr_o,
  output logic [127:0]   feat_guid_o,
  output logic [AW-1:0]  feat_regaddr_o,
  output logic           feat_regabs_o,
  output logic [31:0]    feat_regsize_o,
  output logic [14:0]    feat_group_o,
  output logic [15:0]    feat_inst_o,
  output logic           param_valid_o,
  output logic [15:0]    param_id_o,
  output logic [15:0]    param_ver_o,
  output logic           done_o,
  output logic           err_o,
  output logic [FCW-1:0] count_o
);
  localparam logic [AW-1:0] OFS_GL  = AW'(8);
  localparam logic [AW-1:0] OFS_GH  = AW'(16);
  localparam logic [AW-1:0] OFS_LOC = AW'(24);
  localparam logic [AW-1:0] OFS_SZ  = AW'(32);
  localparam logic [AW-1:0] OFS_PRM = AW'(40);

  logic rst_i_n;
  walk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  state_e        state_q, state_d;
  fetch_e        kind_q, kind_d;
  logic [AW-1:0] hdr_q, hdr_d, prm_q, prm_d, loc_q, loc_d, iss_addr;
  hdr_t          h0_q, h0_d, nh;
  logic [127:0]  guid_q, guid_d;
  size_t         sz_q, sz_d;
  prm_t          pw_q, pw_d;
  logic          err_q, err_d;
  logic          issue, resp_ok, fclr, finc, pclr, pinc, is_v1;
  logic [FCW-1:0] fcnt;
  logic [PCW-1:0] pcnt;

  walk_rd_port #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_i_n), .issue_i(issue), .addr_i(iss_addr),
    .rd_valid_i(rd_valid_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .resp_ok_o(resp_ok)
  );

  walk_limit #(.MAX(MAX_FEAT)) u_flim (
    .clk(clk), .rst_n(rst_i_n), .clr_i(fclr), .inc_i(finc), .cnt_o(fcnt)
  );

  walk_limit #(.MAX(MAX_PARAM)) u_plim (
    .clk(clk), .rst_n(rst_i_n), .clr_i(pclr), .inc_i(pinc), .cnt_o(pcnt)
  );

  assign issue = (state_q == S_ISSUE);
  assign finc  = (state_q == S_EMITF);
  assign pinc  = resp_ok && (kind_q == K_PRM);
  assign is_v1 = (h0_q.ver == 8'd1);
  assign nh    = unpack_hdr(rd_data_i);

  always_comb begin
    case (kind_q)
      K_GL:    iss_addr = hdr_q + OFS_GL;
      K_GH:    iss_addr = hdr_q + OFS_GH;
      K_LOC:   iss_addr = hdr_q + OFS_LOC;
      K_SZ:    iss_addr = hdr_q + OFS_SZ;
      K_PRM:   iss_addr = prm_q;
      default: iss_addr = hdr_q;
    endcase
  end

  always_comb begin
    state_d = state_q; kind_d = kind_q; hdr_d = hdr_q; prm_d = prm_q;
    h0_d = h0_q; guid_d = guid_q; loc_d = loc_q; sz_d = sz_q; pw_d = pw_q;
    err_d = err_q; fclr = 1'b0; pclr = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        fclr = 1'b1; err_d = 1'b0; hdr_d = base_i; kind_d = K_H0;
        if (base_i[2:0] != 3'b000) begin
          err_d = 1'b1; state_d = S_DONE;
        end else state_d = S_ISSUE;
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: if (resp_ok) begin
        case (kind_q)
          K_H0: begin
            h0_d = nh; guid_d = '0; loc_d = '0; sz_d = '0;
            if (nh.ver == 8'd1 || nh.kind == GUID_KIND_A || nh.kind == GUID_KIND_B) begin
              kind_d = K_GL; state_d = S_ISSUE;
            end else state_d = S_EMITF;
          end
          K_GL: begin guid_d[63:0] = rd_data_i; kind_d = K_GH; state_d = S_ISSUE; end
          K_GH: begin
            guid_d[127:64] = rd_data_i;
            if (is_v1) begin kind_d = K_LOC; state_d = S_ISSUE; end
            else state_d = S_EMITF;
          end
          K_LOC: begin loc_d = rd_data_i[AW-1:0]; kind_d = K_SZ; state_d = S_ISSUE; end
          K_SZ:  begin sz_d = size_t'(rd_data_i); state_d = S_EMITF; end
          default: begin pw_d = unpack_prm(rd_data_i); state_d = S_EMITP; end
        endcase
      end
      S_EMITF: if (is_v1 && sz_q.pflag) begin
        pclr = 1'b1; prm_d = hdr_q + OFS_PRM; kind_d = K_PRM; state_d = S_ISSUE;
      end else state_d = S_ADV;
      S_EMITP: if (pw_q.pend) state_d = S_ADV;
      else if (pw_q.nxt == '0 || pcnt == PCW'(MAX_PARAM)) begin
        err_d = 1'b1; state_d = S_DONE;
      end else begin
        prm_d = prm_q + AW'({pw_q.nxt, 3'b000}); state_d = S_ISSUE;
      end
      S_ADV: if (h0_q.last) state_d = S_DONE;
      else if (h0_q.nxt == '0 || h0_q.nxt[2:0] != 3'b000 || fcnt == FCW'(MAX_FEAT)) begin
        err_d = 1'b1; state_d = S_DONE;
      end else begin
        hdr_d = hdr_q + AW'(h0_q.nxt); kind_d = K_H0; state_d = S_ISSUE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_IDLE; kind_q <= K_H0; hdr_q <= '0; prm_q <= '0;
      h0_q <= '0; guid_q <= '0; loc_q <= '0; sz_q <= '0; pw_q <= '0; err_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; hdr_q <= hdr_d; prm_q <= prm_d;
      h0_q <= h0_d; guid_q <= guid_d; loc_q <= loc_d; sz_q <= sz_d; pw_q <= pw_d;
      err_q <= err_d;
    end
  end

  assign feat_valid_o   = (state_q == S_EMITF);
  assign feat_type_o    = h0_q.kind;
  assign feat_ver_o     = h0_q.ver;
  assign feat_id_o      = h0_q.id;
  assign feat_rev_o     = h0_q.rev;
  assign feat_addr_o    = hdr_q;
  assign feat_guid_o    = guid_q;
  assign feat_regabs_o  = loc_q[0];
  assign feat_regaddr_o = loc_q[0] ? {loc_q[AW-1:1], 1'b0} : hdr_q + {loc_q[AW-1:1], 1'b0};
  assign feat_regsize_o = sz_q.rsize;
  assign feat_group_o   = sz_q.grp;
  assign feat_inst_o    = sz_q.inst;
  assign param_valid_o  = (state_q == S_EMITP);
  assign param_id_o     = pw_q.id;
  assign param_ver_o    = pw_q.ver;
  assign done_o         = (state_q == S_DONE);
  assign err_o          = err_q;
  assign count_o        = fcnt;
endmodule

// File: rtl/hdr_walker_chk.sv
module hdr_walker_chk #(
  parameter int AW       = 32,
  parameter int CW       = 5,
  parameter int MAX_FEAT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_valid_i,
  input logic          feat_valid_o,
  input logic          param_valid_o,
  input logic          done_o,
  input logic          err_o,
  input logic [CW-1:0] count_o
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst_q <= 1'b0;
    else if (rd_req_o)   outst_q <= 1'b1;
    else if (rd_valid_i) outst_q <= 1'b0;
  end

  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !outst_q);

  // R11
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o[2:0] == 3'b000));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R13
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != $past(err_o)) |-> (done_o || $past(start_i)));

  // R9
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(MAX_FEAT));

  // R7
  rec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(feat_valid_o && param_valid_o));
endmodule

bind hdr_walker hdr_walker_chk #(.AW(AW), .CW(FCW), .MAX_FEAT(MAX_FEAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .feat_valid_o(feat_valid_o),
  .param_valid_o(param_valid_o), .done_o(done_o), .err_o(err_o), .count_o(count_o)
);

// File: tb/hdr_walker_tb_top.sv
module hdr_walker_tb_top;
  localparam int FW = 284;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        rd_req_o, rd_valid_i = 1'b0;
  logic [31:0] rd_addr_o;
  logic [63:0] rd_data_i = '0;
  logic        feat_valid_o, feat_regabs_o, param_valid_o, done_o, err_o;
  logic [3:0]  feat_type_o, feat_rev_o;
  logic [7:0]  feat_ver_o;
  logic [11:0] feat_id_o;
  logic [31:0] feat_addr_o, feat_regaddr_o, feat_regsize_o;
  logic [127:0] feat_guid_o;
  logic [14:0] feat_group_o;
  logic [15:0] feat_inst_o, param_id_o, param_ver_o;
  logic [4:0]  count_o;

  int checks = 0, errors = 0, prot_bad = 0;
  logic [63:0]   mem [logic [31:0]];
  logic [FW-1:0] fq[$];
  logic [31:0]   pq[$];
  logic [5:0]    dq[$];

  always #10 clk = ~clk;

  hdr_walker dut_i (.*);

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] hw(input logic [3:0] k, input logic [7:0] v, input logic l,
                                     input logic [23:0] n, input logic [3:0] r, input logic [11:0] id);
    return {k, v, 11'h7FF, l, n, r, id};
  endfunction

  function automatic logic [63:0] pw(input logic [28:0] n, input logic e,
                                     input logic [15:0] v, input logic [15:0] id);
    return {n, 2'b11, e, v, id};
  endfunction

  task automatic ef(input logic [3:0] k, input logic [7:0] v, input logic [11:0] id,
                    input logic [3:0] r, input logic [31:0] a, input logic [127:0] g,
                    input logic [31:0] ra, input logic ab, input logic [31:0] sz,
                    input logic [14:0] gr, input logic [15:0] in);
    fq.push_back({k, v, id, r, a, g, ra, ab, sz, gr, in});
  endtask

  task automatic walk(input logic [31:0] base);
    @(negedge clk); start_i = 1'b1; base_i = base;
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  // memory responder with varying latency; also watches the read protocol (R11)
  initial begin
    logic pend = 1'b0;
    int lat = 0;
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        logic [31:0] a;
        if (pend || rd_addr_o[2:0] != 3'b000) prot_bad++;
        pend = 1'b1; a = rd_addr_o;
        repeat (1 + lat) @(negedge clk);
        lat = (lat + 1) % 3;
        rd_valid_i = 1'b1;
        rd_data_i = mem.exists(a) ? mem[a] : 64'h0;
        @(negedge clk);
        rd_valid_i = 1'b0; pend = 1'b0;
        if (rd_req_o) prot_bad++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (feat_valid_o) begin
        if (fq.size() == 0) begin checks++; errors++; $display("FAIL R2 R3 unexpected record act=%0h exp=none", feat_addr_o); end
        else chk("R2 R4 R5 R6 record", {feat_type_o, feat_ver_o, feat_id_o, feat_rev_o, feat_addr_o,
                 feat_guid_o, feat_regaddr_o, feat_regabs_o, feat_regsize_o, feat_group_o, feat_inst_o},
                 fq.pop_front());
      end
      if (param_valid_o) begin
        if (pq.size() == 0) begin checks++; errors++; $display("FAIL R7 unexpected param act=%0h exp=none", param_id_o); end
        else chk("R7 param", FW'({param_id_o, param_ver_o}), FW'(pq.pop_front()));
      end
      if (done_o) begin
        if (dq.size() == 0) begin checks++; errors++; $display("FAIL R3 unexpected done act=1 exp=0"); end
        else chk("R3 R8 R9 R10 done err/count", FW'({err_o, count_o}), FW'(dq.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // test A: mixed chain (R2 R3 R4 R5 R6 R7), with a start pulse mid-walk (R12)
    mem[32'h1000] = hw(4, 0, 0, 24'h40, 2, 12'h001);
    mem[32'h1008] = 64'h1111_2222_3333_4444; mem[32'h1010] = 64'h5555_6666_7777_8888;
    mem[32'h1040] = hw(3, 0, 0, 24'h100, 1, 12'h00A);
    mem[32'h1140] = hw(3, 1, 0, 24'h80, 0, 12'h012);
    mem[32'h1148] = 64'hAAAA_0000_0000_0001; mem[32'h1150] = 64'hBBBB_0000_0000_0002;
    mem[32'h1158] = 64'h200; mem[32'h1160] = {32'h1000, 1'b1, 15'd5, 16'd2};
    mem[32'h1168] = pw(3, 0, 16'd1, 16'h0001); mem[32'h1180] = pw(0, 1, 16'd2, 16'h0007);
    mem[32'h11C0] = hw(1, 1, 1, 24'h1000, 3, 12'h000);
    mem[32'h11C8] = 64'hC0; mem[32'h11D0] = 64'hC1;
    mem[32'h11D8] = 64'h8000_0001; mem[32'h11E0] = {32'h400, 1'b0, 15'd0, 16'd0};
    // test B: accelerator kind, old layout, misaligned next (R4 R8)
    mem[32'h2000] = hw(1, 0, 0, 24'h44, 0, 12'h020);
    mem[32'h2008] = 64'h0D; mem[32'h2010] = 64'h0E;
    // test C: zero next (R8)
    mem[32'h3000] = hw(3, 0, 0, 24'h0, 0, 12'h030);
    // test D: runaway chain (R9)
    for (int k = 0; k < 17; k++) mem[32'h5000 + 8 * k] = hw(3, 0, 0, 24'h8, 0, 12'(k));
    // test E: zero parameter next (R10)
    mem[32'h6000] = hw(3, 1, 0, 24'h40, 0, 12'h060);
    mem[32'h6020] = {32'h10, 1'b1, 15'd0, 16'd0};
    mem[32'h6028] = pw(0, 0, 16'd3, 16'h0009);
    // test F: parameter runaway (R10)
    mem[32'h7000] = hw(3, 1, 0, 24'h80, 0, 12'h070);
    mem[32'h7020] = {32'h20, 1'b1, 15'd1, 16'd1};
    for (int k = 0; k < 5; k++) mem[32'h7028 + 8 * k] = pw(1, 0, 16'd0, 16'(16'h40 + k));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_req", FW'(rd_req_o), '0);
    chk("R1 valids", FW'({feat_valid_o, param_valid_o}), '0);
    chk("R1 done/err/count", FW'({done_o, err_o, count_o}), '0);

    ef(4, 0, 12'h001, 2, 32'h1000, {64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444}, 32'h1000, 0, 0, 0, 0);
    ef(3, 0, 12'h00A, 1, 32'h1040, '0, 32'h1040, 0, 0, 0, 0);
    ef(3, 1, 12'h012, 0, 32'h1140, {64'hBBBB_0000_0000_0002, 64'hAAAA_0000_0000_0001}, 32'h1340, 0, 32'h1000, 15'd5, 16'd2);
    pq.push_back({16'h0001, 16'd1}); pq.push_back({16'h0007, 16'd2});
    ef(1, 1, 12'h000, 3, 32'h11C0, {64'hC1, 64'hC0}, 32'h8000_0000, 1, 32'h400, 0, 0);
    dq.push_back({1'b0, 5'd4});
    @(negedge clk); start_i = 1'b1; base_i = 32'h1000;
    @(negedge clk); start_i = 1'b0;
    repeat (6) @(negedge clk);
    start_i = 1'b1; base_i = 32'h5000; // R12 ignored while walking
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);

    ef(1, 0, 12'h020, 0, 32'h2000, {64'h0E, 64'h0D}, 32'h2000, 0, 0, 0, 0);
    dq.push_back({1'b1, 5'd1});
    walk(32'h2000);
    repeat (3) @(negedge clk);
    chk("R13 err/count held", FW'({err_o, count_o}), FW'({1'b1, 5'd1}));

    ef(3, 0, 12'h030, 0, 32'h3000, '0, 32'h3000, 0, 0, 0, 0);
    dq.push_back({1'b1, 5'd1});
    walk(32'h3000);

    for (int k = 0; k < 16; k++) ef(3, 0, 12'(k), 0, 32'h5000 + 8 * k, '0, 32'h5000 + 8 * k, 0, 0, 0, 0);
    dq.push_back({1'b1, 5'd16});
    walk(32'h5000);

    ef(3, 1, 12'h060, 0, 32'h6000, '0, 32'h6000, 0, 32'h10, 0, 0);
    pq.push_back({16'h0009, 16'd3});
    dq.push_back({1'b1, 5'd1});
    walk(32'h6000);

    ef(3, 1, 12'h070, 0, 32'h7000, '0, 32'h7000, 0, 32'h20, 15'd1, 16'd1);
    for (int k = 0; k < 4; k++) pq.push_back({16'(16'h40 + k), 16'd0});
    dq.push_back({1'b1, 5'd1});
    walk(32'h7000);

    // R8 misaligned base: no record, error, count cleared
    dq.push_back({1'b1, 5'd0});
    walk(32'h7804);

    chk("R11 read protocol violations", FW'(prot_bad), '0);
    chk("R3 all expected items seen", FW'(fq.size() + pq.size() + dq.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule